// File: doc/BRIEF.md
# SPI master transfer engine

This block is the serial shift engine of an SPI master. It takes 8-bit words from the read port of a transmit FIFO and puts received words into the write port of a receive FIFO. It drives SCK, MOSI and four chip-select lines, and it samples MISO. The FIFOs, the clock divider and the register bus sit outside the block. The divider supplies a one-cycle `sck_tick`, and each tick advances SCK by one half period.

Software writes a single control word. That word sets clock phase and polarity, chip-select polarity, which chip select is used, a manual chip-select mode and its level, bit order, a mode that discards received bytes, and a start bit. Two 24-bit counts are captured at start. The burst count gives the total number of bytes exchanged. The transmit count gives how many of those bytes come from the transmit FIFO; the bytes after them are shifted out as zeros. One idle cycle separates consecutive bytes, and this cycle fetches the next word. If that word is not yet present, SCK stays idle until it arrives.

Top module: `spi_xfer_engine`

## Requirements
- R1: After reset the control readback is 0, SCK is 0, all four chip-select outputs are 1, and `tx_pop`, `rx_push` and `done` are 0.
- R2: A control write with bit 31 set while idle starts a burst. Readback bit 31 reads 1 from the next cycle until the burst ends. At the end it returns to 0 in the same cycle that `done` is high, and `done` stays high for exactly one cycle.
- R3: Between bytes and while idle, SCK rests at the level of control bit 1 (clock polarity).
- R4: With control bit 0 (phase) clear, MISO is sampled on the leading SCK edge and MOSI changes on the trailing edge. With bit 0 set, MOSI changes on the leading edge and MISO is sampled on the trailing edge. Every byte received is pushed unchanged on `rx_data`.
- R5: With control bit 12 set, each byte is shifted least-significant bit first. With it clear, the most-significant bit goes first. This order applies to both MOSI and MISO.
- R6: The first min(transmit count, burst count) bytes are popped from the transmit FIFO and sent. Every later byte of the burst is sent as 0x00, and no pop occurs for it.
- R7: With control bit 8 set, no byte is pushed to the receive FIFO during the burst.
- R8: Control bits 5:4 select one of the four chip-select lines. Bit 2 gives the active level (1 means active high). The selected line is active while a burst is in progress, and every other line stays at the inactive level.
- R9: With control bit 6 set, the selected chip-select line follows control bit 7 at all times, whether idle or busy.
- R10: If a byte from the transmit FIFO is due and the FIFO is empty, SCK stays at its idle level and the burst waits until data is present.
- R11: Control writes made during a burst change neither the readback fields nor the burst in progress.
- R12: A start with burst count 0 ends with `done` in the following cycle. No pop occurs and SCK does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sck_tick | input | 1 | Half-period enable from the clock divider |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word to write |
| ctl_q | output | 32 | Control readback; bit 31 is the busy flag |
| burst_cnt | input | 24 | Total number of bytes, captured at start |
| tx_cnt | input | 24 | Number of bytes taken from the transmit FIFO, captured at start |
| tx_empty | input | 1 | Transmit FIFO is empty |
| tx_data | input | 8 | Head word of the transmit FIFO (show-ahead) |
| tx_pop | output | 1 | Pops the head word of the transmit FIFO |
| rx_push | output | 1 | Writes `rx_data` into the receive FIFO |
| rx_data | output | 8 | Received byte |
| done | output | 1 | One-cycle pulse at the end of a burst |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_o | output | 4 | Chip-select lines |

## Verification
A bit counter that slips by one shows up within the same byte. SCK makes a wrong number of edges, and the byte pushed on `rx_data` is shifted by one position. The bench's model of the serial device catches both at that byte's boundary. A wrong count of remaining transmit bytes shows up as an extra or missing `tx_pop`, or as a non-zero MOSI byte, on the first byte past the transmit count. A wrong busy or configuration state shows up on the chip-select lines and on the SCK idle level at the next edge, and on the readback immediately.

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sck_tick,
  input  logic             ctl_wr,
  input  logic [31:0]      ctl_wdata,
  output logic [31:0]      ctl_q,
  input  logic [CNT_W-1:0] burst_cnt,
  input  logic [CNT_W-1:0] tx_cnt,
  input  logic             tx_empty,
  input  logic [7:0]       tx_data,
  output logic             tx_pop,
  output logic             rx_push,
  output logic [7:0]       rx_data,
  output logic             done,
  output logic             sck,
  output logic             mosi,
  input  logic             miso,
  output logic [3:0]       cs_o
);
  localparam int NCS = 4;
  localparam logic [3:0] LAST_EDGE = 4'd15;

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_SHIFT} st_t;
  st_t st;

  logic cpha, cpol, spol, manual, level, disc, lsb, busy;
  logic [1:0] sel;
  logic [CNT_W-1:0] rem, txrem;
  logic [7:0] shreg;
  logic [3:0] k;
  logic rbit, lead, mosi_q;

  function automatic logic [7:0] shin(input logic [7:0] v, input logic b, input logic lf);
    return lf ? {b, v[7:1]} : {v[6:0], b};
  endfunction

  function automatic logic outb(input logic [7:0] v, input logic lf);
    return lf ? v[0] : v[7];
  endfunction

  wire cfg_wr  = ctl_wr && !busy;
  wire start   = cfg_wr && ctl_wdata[31];
  wire need_tx = txrem != '0;
  wire more    = rem != '0;
  wire load_go = (st == S_LOAD) && more && (!need_tx || !tx_empty);
  wire [7:0] first = need_tx ? tx_data : 8'h00;
  wire edge_en = sck_tick && (st == S_SHIFT);
  wire last    = edge_en && (k == LAST_EDGE);
  wire smp     = edge_en && (k[0] == cpha);
  wire shf     = edge_en && (k[0] != cpha) && (k != 4'd0) && !last;
  wire [7:0] nxt = shin(shreg, rbit, lsb);
  wire [7:0] fin = shin(shreg, cpha ? miso : rbit, lsb);

  assign tx_pop = (st == S_LOAD) && more && need_tx && !tx_empty;
  assign sck    = cpol ^ lead;
  assign mosi   = mosi_q;
  assign ctl_q  = {busy, 18'b0, lsb, 3'b0, disc, level, manual, sel, 1'b0, spol, cpol, cpha};

  always_comb begin
    for (int i = 0; i < NCS; i++) cs_o[i] = ~spol;
    if (manual) cs_o[sel] = level;
    else        cs_o[sel] = busy ? spol : ~spol;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {cpha, cpol, spol, manual, level, disc, lsb, busy} <= '0;
      sel     <= '0;
      st      <= S_IDLE;
      rem     <= '0;
      txrem   <= '0;
      shreg   <= '0;
      k       <= '0;
      rbit    <= 1'b0;
      lead    <= 1'b0;
      mosi_q  <= 1'b0;
      rx_push <= 1'b0;
      rx_data <= '0;
      done    <= 1'b0;
    end else begin
      rx_push <= 1'b0;
      done    <= 1'b0;
      if (cfg_wr) begin
        cpha   <= ctl_wdata[0];
        cpol   <= ctl_wdata[1];
        spol   <= ctl_wdata[2];
        sel    <= ctl_wdata[5:4];
        manual <= ctl_wdata[6];
        level  <= ctl_wdata[7];
        disc   <= ctl_wdata[8];
        lsb    <= ctl_wdata[12];
      end
      if (start) begin
        busy  <= 1'b1;
        rem   <= burst_cnt;
        txrem <= tx_cnt;
        st    <= S_LOAD;
      end
      case (st)
        S_LOAD: begin
          if (!more) begin
            busy <= 1'b0;
            done <= 1'b1;
            st   <= S_IDLE;
          end else if (load_go) begin
            shreg  <= first;
            mosi_q <= outb(first, lsb);
            if (need_tx) txrem <= txrem - 1'b1;
            k  <= '0;
            st <= S_SHIFT;
          end
        end
        S_SHIFT: begin
          if (edge_en) begin
            k    <= k + 1'b1;
            lead <= ~k[0];
          end
          if (smp) rbit <= miso;
          if (shf) begin
            shreg  <= nxt;
            mosi_q <= outb(nxt, lsb);
          end
          if (last) begin
            shreg   <= fin;
            rx_push <= ~disc;
            rx_data <= fin;
            rem     <= rem - 1'b1;
            st      <= S_LOAD;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/spi_xfer_engine_chk.sv
module spi_xfer_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] ctl_q,
  input logic        sck,
  input logic        tx_pop,
  input logic        tx_empty,
  input logic        rx_push,
  input logic        done,
  input logic [3:0]  cs_o
);
  p_done_clears_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !ctl_q[31]);
  p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_sck_rest_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q[31] |-> (sck == ctl_q[1]));
  p_pop_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> (ctl_q[31] && !tx_empty));
  p_no_push_discard_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[8] |-> !rx_push);
  p_one_cs_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cs_o ^ {4{~ctl_q[2]}}) <= 1);
  p_cfg_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[31] |=> $stable(ctl_q[30:0]));
endmodule

bind spi_xfer_engine spi_xfer_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_q(ctl_q), .sck(sck), .tx_pop(tx_pop),
  .tx_empty(tx_empty), .rx_push(rx_push), .done(done), .cs_o(cs_o)
);

// File: tb/spi_xfer_engine_test.sv
`timescale 1ns/1ps
module spi_xfer_engine_test;
  logic clk = 1'b0, rst_n = 1'b0, sck_tick = 1'b0, ctl_wr = 1'b0;
  logic [31:0] ctl_wdata = '0, ctl_q;
  logic [23:0] burst_cnt = '0, tx_cnt = '0;
  logic tx_empty, tx_pop, rx_push, done, sck, mosi, miso = 1'b0;
  logic [7:0] tx_data, rx_data;
  logic [3:0] cs_o;

  int nvec = 0, nbad = 0, cycles = 0;
  logic [7:0] txb [64];
  logic [7:0] slv [64];
  int rd = 0, avail = 0, txn = 0, tdiv = 0;
  int sidx = 0, sb = 0, ridx = 0;
  bit act = 0, psck = 0;
  bit c_cpha, c_cpol, c_spol, c_man, c_lvl, c_disc, c_lsb;
  bit [1:0] c_sel;
  logic [7:0] cap;

  assign tx_empty = (rd >= avail);
  assign tx_data  = txb[rd % 64];

  spi_xfer_engine uut (.*);

  initial forever #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int a, input int e);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, a, e);
    end
  endtask

  function automatic logic [3:0] exp_cs(input bit busy);
    logic [3:0] v = {4{~c_spol}};
    v[c_sel] = c_man ? c_lvl : (busy ? c_spol : ~c_spol);
    return v;
  endfunction

  function automatic logic sbit(input int idx, input int b);
    return c_lsb ? slv[idx % 64][b] : slv[idx % 64][7 - b];
  endfunction

  initial forever begin
    @(negedge clk);
    cycles++;
    if (cycles > 190000) begin
      nbad++;
      $display("FAIL watchdog actual=%0d expected=<190000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial forever begin
    @(negedge clk);
    sck_tick = (tdiv == 0) ? 1'b1 : (($urandom % tdiv) == 0);
  end

  initial forever begin
    @(posedge clk);
    if (tx_pop) rd <= rd + 1;
  end

  // serial device model: drives MISO and captures MOSI per mode
  initial forever begin
    @(negedge clk);
    if (act) begin
      if (sck != psck) begin
        chk(cs_o == exp_cs(1), c_man ? "R9" : "R8", cs_o, exp_cs(1));
        if (psck == c_cpol) begin
          if (!c_cpha) cap[sb] = mosi;
          else miso = sbit(sidx, sb);
        end else begin
          if (c_cpha) cap[sb] = mosi;
          sb++;
          if (sb == 8) begin
            logic [7:0] got, e;
            for (int j = 0; j < 8; j++) got[c_lsb ? j : 7 - j] = cap[j];
            e = (sidx < txn) ? txb[sidx % 64] : 8'h00;
            chk(got == e, (sidx < txn) ? (c_lsb ? "R5 mosi" : "R4 mosi") : "R6 zero fill", got, e);
            sidx++;
            sb = 0;
          end
          if (!c_cpha) miso = sbit(sidx, sb);
        end
        psck = sck;
      end
      if (rx_push) begin
        if (c_disc) chk(0, "R7 push while discarding", 1, 0);
        else begin
          chk(rx_data == slv[ridx % 64], c_lsb ? "R5 rx" : "R4 rx", rx_data, slv[ridx % 64]);
          ridx++;
        end
      end
    end
  end

  task automatic run(input bit cpha_, cpol_, spol_, man_, lvl_, disc_, lsb_,
                     input bit [1:0] sel_, input int n, input int t, input int extra,
                     input bit stall, input bit midwr);
    logic [31:0] cfg;
    int cyc, lim;
    for (int i = 0; i < 64; i++) begin
      txb[i] = 8'($urandom);
      slv[i] = 8'($urandom);
    end
    {c_cpha, c_cpol, c_spol, c_man, c_lvl, c_disc, c_lsb, c_sel} =
      {cpha_, cpol_, spol_, man_, lvl_, disc_, lsb_, sel_};
    cfg = {19'b0, lsb_, 3'b0, disc_, lvl_, man_, sel_, 1'b0, spol_, cpol_, cpha_};
    txn = t; sidx = 0; sb = 0; ridx = 0; cap = '0;
    @(negedge clk);
    rd = 0;
    avail = stall ? 1 : t + extra;
    burst_cnt = 24'(n);
    tx_cnt = 24'(t);
    ctl_wr = 1'b1; ctl_wdata = cfg;
    @(negedge clk);
    ctl_wr = 1'b0;
    chk(sck == cpol_, "R3 idle level", sck, cpol_);
    chk(cs_o == exp_cs(0), man_ ? "R9 idle" : "R8 idle", cs_o, exp_cs(0));
    chk(ctl_q[30:0] == cfg[30:0], "R2 readback", ctl_q, cfg);
    psck = sck;
    miso = cpha_ ? 1'b0 : sbit(0, 0);
    act = 1;
    ctl_wr = 1'b1; ctl_wdata = cfg | 32'h8000_0000;
    @(negedge clk);
    ctl_wr = 1'b0;
    chk(ctl_q[31] == 1'b1, "R2 busy", ctl_q[31], 1);
    if (midwr) begin
      ctl_wr = 1'b1; ctl_wdata = (cfg ^ 32'h0000_1133) | 32'h8000_0000;
      @(negedge clk);
      ctl_wr = 1'b0;
    end
    if (stall) begin
      for (int i = 0; i < 60; i++) @(negedge clk);
      chk(sck == cpol_, "R10 sck held", sck, cpol_);
      chk(rd == 1, "R10 no pop while empty", rd, 1);
      chk(ctl_q[31] == 1'b1, "R10 still busy", ctl_q[31], 1);
      avail = t + extra;
    end
    cyc = 0;
    lim = 20000;
    do begin
      if (!done) begin @(negedge clk); cyc++; end
    end while (!done && cyc < lim);
    chk(done == 1'b1, "R2 done", done, 1);
    chk(ctl_q[31] == 1'b0, "R2 busy cleared", ctl_q[31], 0);
    if (n == 0) begin
      chk(cyc == 1, "R12 immediate done", cyc, 1);
      chk(sck == cpol_, "R12 sck still", sck, cpol_);
    end
    @(negedge clk);
    act = 0;
    chk(done == 1'b0, "R2 single pulse", done, 0);
    chk(sidx == n && sb == 0, "R4 byte count", sidx, n);
    chk(ridx == (disc_ ? 0 : n), "R7 push count", ridx, disc_ ? 0 : n);
    chk(rd == ((t < n) ? t : n), "R6 pop count", rd, (t < n) ? t : n);
    chk(sck == cpol_, "R3 rest level", sck, cpol_);
    chk(cs_o == exp_cs(0), man_ ? "R9 after" : "R8 after", cs_o, exp_cs(0));
    if (midwr) chk(ctl_q == cfg, "R11 write ignored", ctl_q, cfg);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    chk(ctl_q == 32'h0, "R1 ctl", ctl_q, 0);
    chk(sck == 1'b0, "R1 sck", sck, 0);
    chk(cs_o == 4'hF, "R1 cs", cs_o, 4'hF);
    chk({tx_pop, rx_push, done} == 3'b000, "R1 strobes", {tx_pop, rx_push, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ctl_q == 32'h0 && sck == 1'b0 && cs_o == 4'hF, "R1 after release", ctl_q, 0);

    tdiv = 0;
    run(0,0,0,0,0,0,0, 2'd0, 4, 4, 2, 0, 0);
    run(1,0,0,0,0,0,0, 2'd1, 4, 4, 0, 0, 0);
    run(0,1,1,0,0,0,1, 2'd2, 3, 3, 0, 0, 0);
    run(1,1,0,0,0,0,1, 2'd3, 3, 3, 0, 0, 0);
    run(0,0,0,0,0,1,0, 2'd0, 5, 5, 0, 0, 0);
    run(1,0,1,0,0,0,0, 2'd1, 6, 2, 3, 0, 0);
    run(0,1,0,0,0,0,0, 2'd2, 3, 0, 2, 0, 0);
    run(0,0,0,0,0,0,0, 2'd3, 4, 9, 0, 0, 0);
    run(0,0,0,1,0,0,0, 2'd2, 2, 2, 0, 0, 0);
    run(1,1,1,1,1,0,0, 2'd1, 2, 2, 0, 0, 0);
    run(0,0,0,0,0,0,0, 2'd0, 0, 3, 0, 0, 0);
    run(1,0,0,0,0,0,0, 2'd0, 3, 3, 0, 1, 0);
    run(0,1,0,0,0,0,1, 2'd1, 4, 4, 0, 0, 1);
    for (int r = 0; r < 30; r++) begin
      int n = 1 + int'($urandom % 20);
      int t = int'($urandom % (n + 3));
      tdiv = int'($urandom % 4);
      run(1'($urandom), 1'($urandom), 1'($urandom), ($urandom % 5) == 0, 1'($urandom),
          ($urandom % 4) == 0, 1'($urandom), 2'($urandom), n, t, int'($urandom % 3), 0,
          ($urandom % 6) == 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule